// File: doc/BRIEF.md
# Software-Triggered Doorbell and Message Interrupt Unit

This block holds one 32-bit doorbell cause register and one 32-bit doorbell enable register for each CPU. A CPU raises doorbells in any set of CPUs by writing a single trigger word. That word carries a 5-bit doorbell number and a bitmap of target CPUs. A second write port takes inbound message-signalled interrupt writes from the fabric and decodes them through the same trigger word. A device that writes data `0xF00 | (16 + k)` to the trigger offset therefore raises doorbell `16 + k` in CPUs 0 to 3.

Each CPU reaches its own cause and enable registers through the host port. It selects them with its CPU index and an offset. A write to the cause register clears every bit written as 0 and keeps every bit written as 1. For each CPU, doorbells 0 to 7 are reduced into an inter-processor interrupt line, and doorbells 16 to 31 are reduced into a message interrupt line. These two lines feed sources 0 and 1 of that CPU's interrupt controller. Doorbells 8 to 15 are stored in the cause register but reach neither line.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every cause and enable register reads 0, and `ipi_o` and `msi_o` are all low.
- R2: A host write to offset 0x04 sets, on the next clock edge, cause bit `wdata[4:0]` in every CPU `c` whose target bit `wdata[8+c]` is 1. CPUs whose target bit is 0 are left unchanged.
- R3: A message-port write to offset 0x04 is decoded like R2. Data `0xF00 | (16+k)` sets cause bit `16+k` in CPUs 0 to 3. Message-port writes to any other offset have no effect.
- R4: A host write to offset 0x08 of CPU `h_cpu_i` clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R5: A host write to offset 0x0C loads that CPU's enable register. Reading offset 0x0C returns it, and reading offset 0x08 returns the cause register.
- R6: `ipi_o[c]` is high exactly when some cause bit 0 to 7 of CPU `c` is set and its enable bit is 1.
- R7: `msi_o[c]` is high exactly when some cause bit 16 to 31 of CPU `c` is set and its enable bit is 1.
- R8: Doorbells 8 to 15 are latched in the cause register and drive neither summary output.
- R9: When a trigger and a cause-clear write hit the same bit in the same cycle, the bit ends up set.
- R10: Host writes to unmapped offsets change nothing, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_we_i | input | 1 | Host write strobe |
| h_cpu_i | input | CPU_W | Index of the CPU issuing the host access |
| h_addr_i | input | ADDR_W | Host write offset |
| h_wdata_i | input | 32 | Host write data |
| m_we_i | input | 1 | Message write strobe |
| m_addr_i | input | ADDR_W | Message write offset |
| m_wdata_i | input | 32 | Message write data |
| rd_cpu_i | input | CPU_W | CPU index for register read |
| rd_addr_i | input | ADDR_W | Read offset |
| rd_data_o | output | 32 | Read data, combinational |
| ipi_o | output | NUM_CPU | Per-CPU inter-processor doorbell summary |
| msi_o | output | NUM_CPU | Per-CPU message doorbell summary |

## Verification
The hardest case to reach is the same-cycle collision of R9. A host clear of a CPU's cause register must land in the same cycle as a message-port trigger that targets a bit being cleared. The bench reaches it by driving both ports at one falling edge. It then reads the cause back and expects only the triggered bit to remain. The mid-range doorbells of R8 get their own case: every enable bit is set, and both summaries must still stay low.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int DB_W      = 32;
  localparam int DB_IDX_W  = $clog2(DB_W);
  localparam int TGT_LSB   = 8;
  localparam logic [7:0] OFF_TRIG  = 8'h04;
  localparam logic [7:0] OFF_CAUSE = 8'h08;
  localparam logic [7:0] OFF_MASK  = 8'h0C;
  localparam logic [DB_W-1:0] IPI_GRP = 32'h0000_00FF;
  localparam logic [DB_W-1:0] MSI_GRP = 32'hFFFF_0000;
  typedef logic [DB_W-1:0] db_vec_t;
endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
  import db_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DB_W-1:0]               wdata_i,
  output logic [NUM_CPU-1:0][DB_W-1:0]  set_o
);
  logic    hit;
  db_vec_t onehot;

  always_comb begin
    hit    = we_i && (addr_i == ADDR_W'(OFF_TRIG));
    onehot = db_vec_t'(1) << wdata_i[DB_IDX_W-1:0];
    for (int c = 0; c < NUM_CPU; c++) begin
      set_o[c] = (hit && wdata_i[TGT_LSB+c]) ? onehot : '0;
    end
  end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
  import db_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  db_vec_t set_i,
  input  logic    cause_we_i,
  input  logic    mask_we_i,
  input  db_vec_t wdata_i,
  output db_vec_t cause_o,
  output db_vec_t mask_o
);
  db_vec_t cause_q, mask_q, keep;

  // writing 0 clears; a set in the same cycle wins
  assign keep = cause_we_i ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (cause_q & keep) | set_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/db_summary.sv
module db_summary
  import db_pkg::*;
(
  input  db_vec_t cause_i,
  input  db_vec_t mask_i,
  output logic    ipi_o,
  output logic    msi_o
);
  db_vec_t pend;
  assign pend  = cause_i & mask_i;
  assign ipi_o = |(pend & IPI_GRP);
  assign msi_o = |(pend & MSI_GRP);
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import db_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               h_we_i,
  input  logic [CPU_W-1:0]   h_cpu_i,
  input  logic [ADDR_W-1:0]  h_addr_i,
  input  logic [DB_W-1:0]    h_wdata_i,
  input  logic               m_we_i,
  input  logic [ADDR_W-1:0]  m_addr_i,
  input  logic [DB_W-1:0]    m_wdata_i,
  input  logic [CPU_W-1:0]   rd_cpu_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DB_W-1:0]    rd_data_o,
  output logic [NUM_CPU-1:0] ipi_o,
  output logic [NUM_CPU-1:0] msi_o
);
  logic [NUM_CPU-1:0][DB_W-1:0] h_set, m_set, cause_w, mask_w;

  db_trig_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_h_dec (
    .we_i(h_we_i), .addr_i(h_addr_i), .wdata_i(h_wdata_i), .set_o(h_set)
  );
  db_trig_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_m_dec (
    .we_i(m_we_i), .addr_i(m_addr_i), .wdata_i(m_wdata_i), .set_o(m_set)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic own, cause_we, mask_we;
    assign own      = h_we_i && (h_cpu_i == CPU_W'(c));
    assign cause_we = own && (h_addr_i == ADDR_W'(OFF_CAUSE));
    assign mask_we  = own && (h_addr_i == ADDR_W'(OFF_MASK));

    db_cpu_bank u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(h_set[c] | m_set[c]),
      .cause_we_i(cause_we), .mask_we_i(mask_we), .wdata_i(h_wdata_i),
      .cause_o(cause_w[c]), .mask_o(mask_w[c])
    );

    db_summary u_sum (
      .cause_i(cause_w[c]), .mask_i(mask_w[c]),
      .ipi_o(ipi_o[c]), .msi_o(msi_o[c])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (rd_cpu_i == CPU_W'(c)) begin
        if (rd_addr_i == ADDR_W'(OFF_CAUSE)) rd_data_o = cause_w[c];
        if (rd_addr_i == ADDR_W'(OFF_MASK))  rd_data_o = mask_w[c];
      end
    end
  end
endmodule

// File: rtl/doorbell_unit_chk.sv
module doorbell_unit_chk
  import db_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8,
  parameter int CPU_W   = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         h_we_i,
  input logic [CPU_W-1:0]             h_cpu_i,
  input logic [ADDR_W-1:0]            h_addr_i,
  input logic [DB_W-1:0]              h_wdata_i,
  input logic                         m_we_i,
  input logic [ADDR_W-1:0]            m_addr_i,
  input logic [DB_W-1:0]              m_wdata_i,
  input logic [NUM_CPU-1:0][DB_W-1:0] cause_w,
  input logic [NUM_CPU-1:0][DB_W-1:0] mask_w,
  input logic [NUM_CPU-1:0]           ipi_o,
  input logic [NUM_CPU-1:0]           msi_o
);
  logic h_trig, m_trig;
  assign h_trig = h_we_i && (h_addr_i == ADDR_W'(OFF_TRIG));
  assign m_trig = m_we_i && (m_addr_i == ADDR_W'(OFF_TRIG));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    p_host_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (h_trig && h_wdata_i[TGT_LSB+c]) |=> cause_w[c][$past(h_wdata_i[DB_IDX_W-1:0])]);

    // R3 and R9: a message trigger lands even under a concurrent clear
    p_msg_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_trig && m_wdata_i[TGT_LSB+c]) |=> cause_w[c][$past(m_wdata_i[DB_IDX_W-1:0])]);

    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (h_we_i && h_cpu_i == CPU_W'(c) && h_addr_i == ADDR_W'(OFF_CAUSE) && !m_trig)
      |=> cause_w[c] == ($past(cause_w[c]) & $past(h_wdata_i)));

    p_mask_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (h_we_i && h_cpu_i == CPU_W'(c) && h_addr_i == ADDR_W'(OFF_MASK))
      |=> mask_w[c] == $past(h_wdata_i));

    p_ipi_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cause_w[c] & mask_w[c] & IPI_GRP) == '0) |-> !ipi_o[c]);

    p_msi_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cause_w[c] & mask_w[c] & MSI_GRP) == '0) |-> !msi_o[c]);
  end
endmodule

bind doorbell_unit doorbell_unit_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .h_we_i(h_we_i), .h_cpu_i(h_cpu_i), .h_addr_i(h_addr_i), .h_wdata_i(h_wdata_i),
  .m_we_i(m_we_i), .m_addr_i(m_addr_i), .m_wdata_i(m_wdata_i),
  .cause_w(cause_w), .mask_w(mask_w), .ipi_o(ipi_o), .msi_o(msi_o)
);

// File: tb/doorbell_unit_bench.sv
module doorbell_unit_bench;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int CW = 2;

  logic          clk_i = 0, rst_ni = 0;
  logic          h_we_i = 0, m_we_i = 0;
  logic [CW-1:0] h_cpu_i = '0, rd_cpu_i = '0;
  logic [AW-1:0] h_addr_i = '0, m_addr_i = '0, rd_addr_i = '0;
  logic [31:0]   h_wdata_i = '0, m_wdata_i = '0, rd_data_o;
  logic [NC-1:0] ipi_o, msi_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  doorbell_unit #(.NUM_CPU(NC), .ADDR_W(AW)) u_doorbell_unit (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(int cpu, logic [7:0] addr, logic [31:0] data);
    @(negedge clk_i);
    h_we_i = 1; h_cpu_i = CW'(cpu); h_addr_i = addr; h_wdata_i = data;
    @(negedge clk_i);
    h_we_i = 0;
  endtask

  task automatic msg_wr(logic [7:0] addr, logic [31:0] data);
    @(negedge clk_i);
    m_we_i = 1; m_addr_i = addr; m_wdata_i = data;
    @(negedge clk_i);
    m_we_i = 0;
  endtask

  task automatic rd(int cpu, logic [7:0] addr, output logic [31:0] d);
    rd_cpu_i = CW'(cpu); rd_addr_i = addr;
    #1 d = rd_data_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      rd(c, 8'h08, d); check("R1 cause", d, 0);
      rd(c, 8'h0C, d); check("R1 mask", d, 0);
    end
    check("R1 ipi", {28'd0, ipi_o}, 0);
    check("R1 msi", {28'd0, msi_o}, 0);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    host_wr(1, 8'h04, (32'b0101 << 8) | 32'd3);
    rd(0, 8'h08, d); check("R2 cpu0", d, 32'h8);
    rd(1, 8'h08, d); check("R2 cpu1", d, 32'h0);
    rd(2, 8'h08, d); check("R2 cpu2", d, 32'h8);
    rd(3, 8'h08, d); check("R2 cpu3", d, 32'h0);
    check("R6 masked", {28'd0, ipi_o}, 0);
  endtask

  task automatic t_ipi();
    logic [31:0] d;
    host_wr(0, 8'h0C, 32'hFF);
    rd(0, 8'h0C, d); check("R5 mask rd", d, 32'hFF);
    check("R6 ipi0", {31'd0, ipi_o[0]}, 1);
    host_wr(2, 8'h0C, 32'h1);
    check("R6 ipi2 off", {31'd0, ipi_o[2]}, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    host_wr(0, 8'h04, (32'b0001 << 8) | 32'd5);
    rd(0, 8'h08, d); check("R2 cpu0 two", d, 32'h28);
    host_wr(0, 8'h08, ~32'h8);
    rd(0, 8'h08, d); check("R4 partial", d, 32'h20);
    rd(2, 8'h08, d); check("R4 other cpu", d, 32'h8);
    host_wr(0, 8'h08, 32'h0);
    rd(0, 8'h08, d); check("R4 all", d, 32'h0);
    check("R6 ipi0 low", {31'd0, ipi_o[0]}, 0);
  endtask

  task automatic t_msi();
    logic [31:0] d;
    msg_wr(8'h04, 32'hF00 | 32'd21);
    rd(1, 8'h08, d); check("R3 cpu1", d, 32'h0020_0000);
    rd(2, 8'h08, d); check("R3 cpu2", d, 32'h0020_0008);
    check("R7 masked", {28'd0, msi_o}, 0);
    host_wr(1, 8'h0C, 32'hFFFF_0000);
    check("R7 msi1", {28'd0, msi_o}, 32'b0010);
    msg_wr(8'h08, 32'h0);
    rd(1, 8'h08, d); check("R3 bad offset", d, 32'h0020_0000);
  endtask

  task automatic t_mid();
    logic [31:0] d;
    host_wr(3, 8'h08, 32'h0);
    host_wr(3, 8'h0C, 32'hFFFF_FFFF);
    host_wr(0, 8'h04, (32'b1000 << 8) | 32'd12);
    rd(3, 8'h08, d); check("R8 latched", d, 32'h1000);
    check("R8 ipi3", {31'd0, ipi_o[3]}, 0);
    check("R8 msi3", {31'd0, msi_o[3]}, 0);
  endtask

  task automatic t_conflict();
    logic [31:0] d;
    @(negedge clk_i);
    h_we_i = 1; h_cpu_i = 2'd3; h_addr_i = 8'h08; h_wdata_i = 32'h0;
    m_we_i = 1; m_addr_i = 8'h04; m_wdata_i = (32'b1000 << 8) | 32'd10;
    @(negedge clk_i);
    h_we_i = 0; m_we_i = 0;
    rd(3, 8'h08, d); check("R9 set wins", d, 32'h400);
    check("R6 ipi3 off", {31'd0, ipi_o[3]}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    host_wr(3, 8'h10, 32'hFFFF_FFFF);
    rd(3, 8'h10, d); check("R10 rd zero", d, 0);
    rd(3, 8'h08, d); check("R10 cause kept", d, 32'h400);
    rd(3, 8'h0C, d); check("R10 mask kept", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    #23 rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_trigger();
    t_ipi();
    t_clear();
    t_msi();
    t_mid();
    t_conflict();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule